// File: doc/BRIEF.md
# Speculative Result Rename Pool

This block keeps a small set of rename entries that hold speculative results for general-purpose destinations until their instructions retire. The dispatcher asks for up to two entries per cycle. Each granted request gets the tag of a free entry in the same cycle, and the entry records the architected destination index and the dispatch sequence number it was given. Execution units write results into an entry by tag. Each accepted write is echoed on a broadcast bus, so that waiting consumers can pick up the tag and its data. Lookup ports tell a reservation station whether a tagged value is ready and return that value. A write in the same cycle is forwarded to the lookup.

The entries are kept in dispatch order. The oldest live entry is shown at a head port, with its destination index, data and readiness. The retirement logic pulses a retire input once the instruction's exceptions are handled and every older branch is resolved. The head value is then meant for the architected file, and the entry returns to the free set. A mispredicted branch is reported with its sequence number. Every live entry whose sequence number is younger than the branch's is discarded at once. Older entries keep their data and their place in the order.

Top module: `rename_pool`

## Requirements
- R1: After a synchronous active-low reset, every entry is free, the head port shows no valid entry, and no lookup reports ready.
- R2: A granted slot receives the lowest-numbered free entry. Slot 0 is served before slot 1, so slot 1 gets the next lowest free entry. Tags and grants are valid in the same cycle as the request, and the entry is occupied from the next cycle.
- R3: A slot is granted only if a free entry is left for it. Slot 1 is granted only when slot 0 is requested and granted in the same cycle. No slot is granted in a cycle with a flush.
- R4: A write to an occupied entry stores the data, marks the entry ready, and in the same cycle drives the broadcast valid with that tag and data. A write to a free entry leaves no trace: no broadcast, and the entry is not ready once it is later allocated.
- R5: A lookup of an occupied entry reports ready only after its result has been written, and then returns the stored value. A lookup of a free entry reports not ready.
- R6: A lookup whose tag matches an accepted write in the same cycle reports ready and returns the written data.
- R7: The head port shows the oldest occupied entry in dispatch order, with slot 0 older than slot 1. It gives that entry's tag, destination index, data and readiness. A retire pulse frees the head only when the head is ready. Otherwise the pulse is ignored.
- R8: A flush frees every occupied entry whose sequence number is younger than the branch's. Younger means that the difference entry minus branch, taken modulo 2^SEQ_W, is nonzero and below half the range. Surviving entries keep their order. In the flush cycle, a write to a freed entry is dropped and a retire pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| disp_req_i | input | 2 | Allocation request per dispatch slot |
| disp_areg_i | input | 2 x AREG_W | Architected destination index per slot |
| disp_seq_i | input | 2 x SEQ_W | Dispatch sequence number per slot |
| disp_gnt_o | output | 2 | Allocation granted per slot |
| disp_tag_o | output | 2 x TAG_W | Allocated entry tag per slot |
| wr_en_i | input | 1 | Result write strobe |
| wr_tag_i | input | TAG_W | Entry written |
| wr_data_i | input | DATA_W | Result value |
| bc_valid_o | output | 1 | Broadcast of an accepted write |
| bc_tag_o | output | TAG_W | Broadcast tag |
| bc_data_o | output | DATA_W | Broadcast data |
| lk_tag_i | input | NUM_LK x TAG_W | Lookup tag per port |
| lk_ready_o | output | NUM_LK | Value available per port |
| lk_data_o | output | NUM_LK x DATA_W | Value per port |
| head_valid_o | output | 1 | An entry is live at the head |
| head_ready_o | output | 1 | Head result is written |
| head_tag_o | output | TAG_W | Head entry tag |
| head_areg_o | output | AREG_W | Head destination index |
| head_data_o | output | DATA_W | Head result value |
| retire_i | input | 1 | Retire the head entry |
| flush_i | input | 1 | Branch mispredict |
| flush_seq_i | input | SEQ_W | Sequence number of the mispredicted branch |

## Verification
The bench builds the pool with five entries, 16-bit data, 5-bit destination indices and two lookup ports. The sequence width is 4 bits, so sequence numbers wrap after sixteen dispatches. A short directed run therefore reaches the modular age comparison: entries numbered 14 and 15 must be kept, while entries numbered 0 and 1 are discarded, by a flush at 15. Five entries against two dispatch slots also make it easy to reach the cases where only one slot fits, where the pool is full, and where retirement order wraps around the order queue.

// File: rtl/rnp_pkg.sv
// Package: shared constants and the modular age comparison for the rename pool.
// Assumes sequence widths below 32 bits and an in-flight window under half the range.
package rnp_pkg;

    // Number of dispatch slots served per cycle.
    localparam int DISP_SLOTS = 2;

    // True when sequence a is younger than sequence b under w-bit wrap-around.
    function automatic logic seq_younger(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input int          w);
        logic [31:0] diff;
        diff = (a - b) & ((32'h1 << w) - 32'h1);
        return (diff != 32'h0) && (diff[w-1] == 1'b0);
    endfunction

endpackage

// File: rtl/rnp_alloc.sv
// Module: free-entry picker. Each dispatch slot takes the lowest free entry
// not yet taken by a lower slot. Grants are given in slot order and are withheld
// during a flush. Purely combinational; the clock is used only by the checks.
module rnp_alloc #(
    parameter int NUM_ENT = 5,
    parameter int TAG_W   = 3,
    parameter int SLOTS   = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_ENT-1:0]          busy_i,
    input  logic [SLOTS-1:0]            req_i,
    input  logic                        flush_i,
    output logic [SLOTS-1:0]            gnt_o,
    output logic [SLOTS-1:0][TAG_W-1:0] tag_o
);

    logic [NUM_ENT-1:0] avail;
    logic               chain;
    logic               found;

    // Pick the lowest free entry per slot and chain the grants in slot order.
    always_comb begin
        avail = ~busy_i;
        chain = 1'b1;
        found = 1'b0;
        gnt_o = '0;
        tag_o = '0;
        for (int s = 0; s < SLOTS; s++) begin
            found = 1'b0;
            for (int e = NUM_ENT - 1; e >= 0; e--) begin
                if (avail[e]) begin
                    tag_o[s] = TAG_W'(e);
                    found    = 1'b1;
                end
            end
            gnt_o[s] = chain && req_i[s] && found && !flush_i;
            chain    = gnt_o[s];
            if (found) begin
                avail[tag_o[s]] = 1'b0;
            end
        end
    end

    // R3: nothing is handed out in a flush cycle.
    assert_no_grant_in_flush_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> (gnt_o == '0));

    // R3: a higher slot is granted only together with every lower slot.
    for (genvar s = 1; s < SLOTS; s++) begin : g_order_chk
        assert_slot_in_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            gnt_o[s] |-> gnt_o[s-1]);
    end

endmodule

// File: rtl/rnp_order.sv
// Module: dispatch-order queue of entry tags. Tags are pushed in slot order and
// the oldest is popped at retirement. A flush cuts the queue down to the count of
// survivors, which works because younger entries always sit at the tail.
// Assumes pushes are contiguous from slot 0 and that nothing is pushed or popped
// in a flush cycle.
module rnp_order #(
    parameter int NUM_ENT = 5,
    parameter int TAG_W   = 3,
    parameter int SLOTS   = 2,
    localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [SLOTS-1:0]            push_i,
    input  logic [SLOTS-1:0][TAG_W-1:0] push_tag_i,
    input  logic                        pop_i,
    input  logic                        flush_i,
    input  logic [CNT_W-1:0]            keep_cnt_i,
    output logic                        head_valid_o,
    output logic [TAG_W-1:0]            head_tag_o,
    output logic [CNT_W-1:0]            count_o
);

    logic [TAG_W-1:0] q_q [NUM_ENT];
    logic [TAG_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TAG_W-1:0] tail;
    logic [CNT_W-1:0] npush;

    // Add k to a queue position, wrapping at the queue depth.
    function automatic logic [TAG_W-1:0] ptr_add(input logic [TAG_W-1:0] p, input int k);
        int sum;
        sum = int'(p) + k;
        if (sum >= NUM_ENT) begin
            sum = sum - NUM_ENT;
        end
        return TAG_W'(sum);
    endfunction

    // Derive the tail position and the number of tags pushed this cycle.
    always_comb begin
        tail  = ptr_add(head_q, int'(cnt_q));
        npush = '0;
        for (int s = 0; s < SLOTS; s++) begin
            npush = npush + CNT_W'(push_i[s]);
        end
    end

    // Move the head and the occupancy count; a flush resets the count to the survivors.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else if (flush_i) begin
            cnt_q <= keep_cnt_i;
        end else begin
            if (pop_i) begin
                head_q <= ptr_add(head_q, 1);
            end
            cnt_q <= cnt_q + npush - CNT_W'(pop_i);
        end
    end

    // Store pushed tags at consecutive tail positions.
    always_ff @(posedge clk_i) begin
        for (int s = 0; s < SLOTS; s++) begin
            if (push_i[s] && !flush_i) begin
                q_q[ptr_add(tail, s)] <= push_tag_i[s];
            end
        end
    end

    assign head_valid_o = (cnt_q != '0);
    assign head_tag_o   = q_q[head_q];
    assign count_o      = cnt_q;

endmodule

// File: rtl/rnp_entries.sv
// Module: rename entry storage. Holds the occupied, ready, destination, sequence
// and data state of each entry. It serves the lookup ports (with same-cycle write
// forwarding) and one read port for the head, and it works out which entries a
// flush kills. Assumes allocation tags name free entries and that a retired tag
// is the head.
module rnp_entries #(
    parameter int NUM_ENT = 5,
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 32,
    parameter int AREG_W  = 5,
    parameter int SEQ_W   = 6,
    parameter int SLOTS   = 2,
    parameter int NUM_LK  = 2,
    localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [SLOTS-1:0]             alloc_en_i,
    input  logic [SLOTS-1:0][TAG_W-1:0]  alloc_tag_i,
    input  logic [SLOTS-1:0][AREG_W-1:0] alloc_areg_i,
    input  logic [SLOTS-1:0][SEQ_W-1:0]  alloc_seq_i,
    input  logic                         wr_en_i,
    input  logic [TAG_W-1:0]             wr_tag_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic                         free_en_i,
    input  logic [TAG_W-1:0]             free_tag_i,
    input  logic                         flush_i,
    input  logic [SEQ_W-1:0]             flush_seq_i,
    input  logic [NUM_LK-1:0][TAG_W-1:0] lk_tag_i,
    output logic [NUM_LK-1:0]            lk_ready_o,
    output logic [NUM_LK-1:0][DATA_W-1:0] lk_data_o,
    input  logic [TAG_W-1:0]             rd_tag_i,
    output logic                         rd_ready_o,
    output logic [AREG_W-1:0]            rd_areg_o,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic                         wr_ok_o,
    output logic [NUM_ENT-1:0]           busy_o,
    output logic [CNT_W-1:0]             keep_cnt_o
);

    logic [NUM_ENT-1:0] busy_q;
    logic [NUM_ENT-1:0] rdy_q;
    logic [AREG_W-1:0]  areg_q [NUM_ENT];
    logic [SEQ_W-1:0]   seq_q  [NUM_ENT];
    logic [DATA_W-1:0]  data_q [NUM_ENT];
    logic [NUM_ENT-1:0] kill;
    logic [NUM_ENT-1:0] alloc_hit;
    logic               wr_in_range;
    logic               wr_ok;

    // Mark the entries a flush discards: occupied and younger than the branch.
    always_comb begin
        for (int e = 0; e < NUM_ENT; e++) begin
            kill[e] = flush_i && busy_q[e] &&
                      rnp_pkg::seq_younger(32'(seq_q[e]), 32'(flush_seq_i), SEQ_W);
        end
    end

    // Decode which entries are being allocated this cycle.
    always_comb begin
        alloc_hit = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int e = 0; e < NUM_ENT; e++) begin
                if (alloc_en_i[s] && int'(alloc_tag_i[s]) == e) begin
                    alloc_hit[e] = 1'b1;
                end
            end
        end
    end

    // Accept a write only into an occupied entry that this cycle's flush does not kill.
    always_comb begin
        wr_in_range = int'(wr_tag_i) < NUM_ENT;
        wr_ok       = wr_en_i && wr_in_range && busy_q[wr_tag_i] && !kill[wr_tag_i];
    end

    // Update the occupied and ready flags: free/kill, then allocate, then write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_q <= '0;
            rdy_q  <= '0;
        end else begin
            for (int e = 0; e < NUM_ENT; e++) begin
                if (kill[e] || (free_en_i && int'(free_tag_i) == e)) begin
                    busy_q[e] <= 1'b0;
                    rdy_q[e]  <= 1'b0;
                end else if (alloc_hit[e]) begin
                    busy_q[e] <= 1'b1;
                    rdy_q[e]  <= 1'b0;
                end else if (wr_ok && int'(wr_tag_i) == e) begin
                    rdy_q[e] <= 1'b1;
                end
            end
        end
    end

    // Capture the destination and sequence at allocation and the data at write.
    always_ff @(posedge clk_i) begin
        for (int e = 0; e < NUM_ENT; e++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (alloc_en_i[s] && int'(alloc_tag_i[s]) == e) begin
                    areg_q[e] <= alloc_areg_i[s];
                    seq_q[e]  <= alloc_seq_i[s];
                end
            end
            if (wr_ok && int'(wr_tag_i) == e) begin
                data_q[e] <= wr_data_i;
            end
        end
    end

    // One lookup port per reservation-station source, with write forwarding.
    for (genvar p = 0; p < NUM_LK; p++) begin : g_lookup
        logic hit_range;
        logic fwd;
        // Resolve readiness and value for one lookup port.
        always_comb begin
            hit_range     = int'(lk_tag_i[p]) < NUM_ENT;
            fwd           = wr_ok && (lk_tag_i[p] == wr_tag_i);
            lk_ready_o[p] = hit_range && busy_q[lk_tag_i[p]] && (rdy_q[lk_tag_i[p]] || fwd);
            if (fwd) begin
                lk_data_o[p] = wr_data_i;
            end else if (hit_range) begin
                lk_data_o[p] = data_q[lk_tag_i[p]];
            end else begin
                lk_data_o[p] = '0;
            end
        end
    end

    // Read the registered state of the head entry.
    always_comb begin
        rd_ready_o = busy_q[rd_tag_i] && rdy_q[rd_tag_i];
        rd_areg_o  = areg_q[rd_tag_i];
        rd_data_o  = data_q[rd_tag_i];
    end

    // Count the entries that survive this cycle's flush.
    always_comb begin
        keep_cnt_o = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            keep_cnt_o = keep_cnt_o + CNT_W'(busy_q[e] && !kill[e]);
        end
    end

    assign wr_ok_o = wr_ok;
    assign busy_o  = busy_q;

    // R8: a killed entry is free on the next cycle.
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_kill_chk
        assert_flush_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flush_i && busy_q[e] &&
             rnp_pkg::seq_younger(32'(seq_q[e]), 32'(flush_seq_i), SEQ_W)) |=> !busy_q[e]);
    end

    // R4: an accepted write leaves its entry ready unless it retires in the same cycle.
    assert_write_marks_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ok && !(free_en_i && free_tag_i == wr_tag_i)) |=> rdy_q[$past(wr_tag_i)]);

endmodule

// File: rtl/rename_pool.sv
// Module: top of the rename pool. It joins the free-entry picker, the entry
// storage and the dispatch-order queue. It gates retirement on head readiness
// and drives the write broadcast.
// Assumes sequence numbers rise in dispatch order, slot 0 before slot 1, and that
// fewer than 2^(SEQ_W-1) numbers are in flight.
module rename_pool #(
    parameter int  NUM_ENT = 5,
    parameter int  DATA_W  = 32,
    parameter int  AREG_W  = 5,
    parameter int  SEQ_W   = 6,
    parameter int  NUM_LK  = 2,
    localparam int TAG_W   = $clog2(NUM_ENT),
    localparam int SLOTS   = rnp_pkg::DISP_SLOTS
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [SLOTS-1:0]              disp_req_i,
    input  logic [SLOTS-1:0][AREG_W-1:0]  disp_areg_i,
    input  logic [SLOTS-1:0][SEQ_W-1:0]   disp_seq_i,
    output logic [SLOTS-1:0]              disp_gnt_o,
    output logic [SLOTS-1:0][TAG_W-1:0]   disp_tag_o,
    input  logic                          wr_en_i,
    input  logic [TAG_W-1:0]              wr_tag_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic                          bc_valid_o,
    output logic [TAG_W-1:0]              bc_tag_o,
    output logic [DATA_W-1:0]             bc_data_o,
    input  logic [NUM_LK-1:0][TAG_W-1:0]  lk_tag_i,
    output logic [NUM_LK-1:0]             lk_ready_o,
    output logic [NUM_LK-1:0][DATA_W-1:0] lk_data_o,
    output logic                          head_valid_o,
    output logic                          head_ready_o,
    output logic [TAG_W-1:0]              head_tag_o,
    output logic [AREG_W-1:0]             head_areg_o,
    output logic [DATA_W-1:0]             head_data_o,
    input  logic                          retire_i,
    input  logic                          flush_i,
    input  logic [SEQ_W-1:0]              flush_seq_i
);

    localparam int CNT_W = $clog2(NUM_ENT + 1);

    logic [NUM_ENT-1:0] busy;
    logic [CNT_W-1:0]   keep_cnt;
    logic [CNT_W-1:0]   count;
    logic               wr_ok;
    logic               head_valid;
    logic               head_ready;
    logic [TAG_W-1:0]   head_tag;
    logic               ret_ok;

    rnp_alloc #(
        .NUM_ENT (NUM_ENT),
        .TAG_W   (TAG_W),
        .SLOTS   (SLOTS)
    ) u_alloc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .busy_i  (busy),
        .req_i   (disp_req_i),
        .flush_i (flush_i),
        .gnt_o   (disp_gnt_o),
        .tag_o   (disp_tag_o)
    );

    rnp_entries #(
        .NUM_ENT (NUM_ENT),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W),
        .AREG_W  (AREG_W),
        .SEQ_W   (SEQ_W),
        .SLOTS   (SLOTS),
        .NUM_LK  (NUM_LK)
    ) u_entries (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .alloc_en_i   (disp_gnt_o),
        .alloc_tag_i  (disp_tag_o),
        .alloc_areg_i (disp_areg_i),
        .alloc_seq_i  (disp_seq_i),
        .wr_en_i      (wr_en_i),
        .wr_tag_i     (wr_tag_i),
        .wr_data_i    (wr_data_i),
        .free_en_i    (ret_ok),
        .free_tag_i   (head_tag),
        .flush_i      (flush_i),
        .flush_seq_i  (flush_seq_i),
        .lk_tag_i     (lk_tag_i),
        .lk_ready_o   (lk_ready_o),
        .lk_data_o    (lk_data_o),
        .rd_tag_i     (head_tag),
        .rd_ready_o   (head_ready),
        .rd_areg_o    (head_areg_o),
        .rd_data_o    (head_data_o),
        .wr_ok_o      (wr_ok),
        .busy_o       (busy),
        .keep_cnt_o   (keep_cnt)
    );

    rnp_order #(
        .NUM_ENT (NUM_ENT),
        .TAG_W   (TAG_W),
        .SLOTS   (SLOTS)
    ) u_order (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .push_i       (disp_gnt_o),
        .push_tag_i   (disp_tag_o),
        .pop_i        (ret_ok),
        .flush_i      (flush_i),
        .keep_cnt_i   (keep_cnt),
        .head_valid_o (head_valid),
        .head_tag_o   (head_tag),
        .count_o      (count)
    );

    // Retire only a live, written head, and never during a flush.
    always_comb begin
        ret_ok = retire_i && head_valid && head_ready && !flush_i;
    end

    assign head_valid_o = head_valid;
    assign head_ready_o = head_valid && head_ready;
    assign head_tag_o   = head_tag;
    assign bc_valid_o   = wr_ok;
    assign bc_tag_o     = wr_tag_i;
    assign bc_data_o    = wr_data_i;

    // R7: the order queue holds exactly the occupied entries.
    assert_queue_matches_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(count) == $countones(busy));

    // R7: a retired head is free on the next cycle.
    assert_retire_frees_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_ok |=> !busy[$past(head_tag)]);

    // R2: a granted slot-0 tag is occupied on the next cycle.
    assert_grant_occupies_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_gnt_o[0] |=> busy[$past(disp_tag_o[0])]);

endmodule

// File: tb/rename_pool_test.sv
// Bench: a table walk of dispatch, write, retire and flush cycles, followed by
// directed checks of lookup, forwarding, head contents, reset and sequence wrap.
module rename_pool_test;

    localparam int CLK_P   = 10;
    localparam int NUM_ENT = 5;
    localparam int DATA_W  = 16;
    localparam int AREG_W  = 5;
    localparam int SEQ_W   = 4;
    localparam int NUM_LK  = 2;
    localparam int TAG_W   = $clog2(NUM_ENT);
    localparam int NVEC    = 17;

    typedef struct packed {
        logic [1:0]  req;
        logic [4:0]  a0;
        logic [4:0]  a1;
        logic [3:0]  s0;
        logic [3:0]  s1;
        logic        we;
        logic [2:0]  wt;
        logic [15:0] wd;
        logic        ret;
        logic        fl;
        logic [3:0]  fs;
        logic [1:0]  egnt;
        logic [2:0]  et0;
        logic [2:0]  et1;
        logic        ebc;
        logic        ehv;
        logic [2:0]  eht;
    } vec_t;

    function automatic vec_t mkv(int req, int a0, int a1, int s0, int s1,
                                 int we, int wt, int wd, int ret, int fl, int fs,
                                 int egnt, int et0, int et1, int ebc, int ehv, int eht);
        vec_t v;
        v.req = 2'(req);  v.a0 = 5'(a0);  v.a1 = 5'(a1);
        v.s0 = 4'(s0);    v.s1 = 4'(s1);
        v.we = 1'(we);    v.wt = 3'(wt);  v.wd = 16'(wd);
        v.ret = 1'(ret);  v.fl = 1'(fl);  v.fs = 4'(fs);
        v.egnt = 2'(egnt); v.et0 = 3'(et0); v.et1 = 3'(et1);
        v.ebc = 1'(ebc);  v.ehv = 1'(ehv); v.eht = 3'(eht);
        return v;
    endfunction

    // req a0 a1 s0 s1 | we wt wd | ret fl fs | egnt et0 et1 ebc ehv eht
    localparam vec_t VEC [NVEC] = '{
        mkv(3, 1, 2, 0, 1,  0, 0, 0,      0, 0, 0,  3, 0, 1, 0, 0, 0),
        mkv(3, 3, 4, 2, 3,  0, 0, 0,      0, 0, 0,  3, 2, 3, 0, 1, 0),
        mkv(3, 5, 6, 4, 5,  0, 0, 0,      0, 0, 0,  1, 4, 0, 0, 1, 0),
        mkv(1, 6, 0, 5, 0,  0, 0, 0,      0, 0, 0,  0, 0, 0, 0, 1, 0),
        mkv(0, 0, 0, 0, 0,  1, 1, 'h11,   0, 0, 0,  0, 0, 0, 1, 1, 0),
        mkv(0, 0, 0, 0, 0,  1, 0, 'h22,   0, 0, 0,  0, 0, 0, 1, 1, 0),
        mkv(0, 0, 0, 0, 0,  0, 0, 0,      1, 0, 0,  0, 0, 0, 0, 1, 0),
        mkv(3, 6, 7, 5, 6,  0, 0, 0,      0, 0, 0,  1, 0, 0, 0, 1, 1),
        mkv(0, 0, 0, 0, 0,  0, 0, 0,      1, 0, 0,  0, 0, 0, 0, 1, 1),
        mkv(0, 0, 0, 0, 0,  0, 0, 0,      1, 0, 0,  0, 0, 0, 0, 1, 2),
        mkv(3, 8, 9, 6, 7,  0, 0, 0,      0, 0, 0,  1, 1, 0, 0, 1, 2),
        mkv(3, 1, 1, 7, 8,  1, 4, 'h44,   0, 1, 3,  0, 0, 0, 0, 1, 2),
        mkv(3, 7, 10, 4, 5, 0, 0, 0,      0, 0, 0,  3, 0, 1, 0, 1, 2),
        mkv(0, 0, 0, 0, 0,  1, 2, 'h33,   0, 0, 0,  0, 0, 0, 1, 1, 2),
        mkv(0, 0, 0, 0, 0,  0, 0, 0,      1, 0, 0,  0, 0, 0, 0, 1, 2),
        mkv(0, 0, 0, 0, 0,  1, 2, 'h99,   0, 0, 0,  0, 0, 0, 0, 1, 3),
        mkv(1, 11, 0, 6, 0, 0, 0, 0,      0, 0, 0,  1, 2, 0, 0, 1, 3)
    };

    logic                          clk = 1'b0;
    logic                          rst_n;
    logic [1:0]                    disp_req;
    logic [1:0][AREG_W-1:0]        disp_areg;
    logic [1:0][SEQ_W-1:0]         disp_seq;
    logic [1:0]                    disp_gnt;
    logic [1:0][TAG_W-1:0]         disp_tag;
    logic                          wr_en;
    logic [TAG_W-1:0]              wr_tag;
    logic [DATA_W-1:0]             wr_data;
    logic                          bc_valid;
    logic [TAG_W-1:0]              bc_tag;
    logic [DATA_W-1:0]             bc_data;
    logic [NUM_LK-1:0][TAG_W-1:0]  lk_tag;
    logic [NUM_LK-1:0]             lk_ready;
    logic [NUM_LK-1:0][DATA_W-1:0] lk_data;
    logic                          head_valid;
    logic                          head_ready;
    logic [TAG_W-1:0]              head_tag;
    logic [AREG_W-1:0]             head_areg;
    logic [DATA_W-1:0]             head_data;
    logic                          retire;
    logic                          flush;
    logic [SEQ_W-1:0]              flush_seq;

    int checks = 0;
    int errors = 0;

    rename_pool #(
        .NUM_ENT (NUM_ENT),
        .DATA_W  (DATA_W),
        .AREG_W  (AREG_W),
        .SEQ_W   (SEQ_W),
        .NUM_LK  (NUM_LK)
    ) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .disp_req_i   (disp_req),
        .disp_areg_i  (disp_areg),
        .disp_seq_i   (disp_seq),
        .disp_gnt_o   (disp_gnt),
        .disp_tag_o   (disp_tag),
        .wr_en_i      (wr_en),
        .wr_tag_i     (wr_tag),
        .wr_data_i    (wr_data),
        .bc_valid_o   (bc_valid),
        .bc_tag_o     (bc_tag),
        .bc_data_o    (bc_data),
        .lk_tag_i     (lk_tag),
        .lk_ready_o   (lk_ready),
        .lk_data_o    (lk_data),
        .head_valid_o (head_valid),
        .head_ready_o (head_ready),
        .head_tag_o   (head_tag),
        .head_areg_o  (head_areg),
        .head_data_o  (head_data),
        .retire_i     (retire),
        .flush_i      (flush),
        .flush_seq_i  (flush_seq)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        disp_req  = '0;
        disp_areg = '0;
        disp_seq  = '0;
        wr_en     = 1'b0;
        wr_tag    = '0;
        wr_data   = '0;
        lk_tag    = '0;
        retire    = 1'b0;
        flush     = 1'b0;
        flush_seq = '0;
    endtask

    // Let one clock edge pass and return just after the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state
        lk_tag[0] = 3'd0;
        lk_tag[1] = 3'd4;
        #1;
        check("R1 head valid", 32'(head_valid), 32'd0);
        check("R1 lookup ready", 32'(lk_ready), 32'd0);

        // Table walk: inputs after the falling edge, outputs sampled 1 time unit later.
        for (int i = 0; i < NVEC; i++) begin
            idle();
            disp_req     = VEC[i].req;
            disp_areg[0] = VEC[i].a0;
            disp_areg[1] = VEC[i].a1;
            disp_seq[0]  = VEC[i].s0;
            disp_seq[1]  = VEC[i].s1;
            wr_en        = VEC[i].we;
            wr_tag       = VEC[i].wt;
            wr_data      = VEC[i].wd;
            retire       = VEC[i].ret;
            flush        = VEC[i].fl;
            flush_seq    = VEC[i].fs;
            #1;
            check($sformatf("R3 grant v%0d", i), 32'(disp_gnt), 32'(VEC[i].egnt));
            if (VEC[i].egnt[0]) check($sformatf("R2 tag0 v%0d", i), 32'(disp_tag[0]), 32'(VEC[i].et0));
            if (VEC[i].egnt[1]) check($sformatf("R2 tag1 v%0d", i), 32'(disp_tag[1]), 32'(VEC[i].et1));
            check($sformatf("R4 broadcast v%0d", i), 32'(bc_valid), 32'(VEC[i].ebc));
            if (VEC[i].ebc) check($sformatf("R4 bc data v%0d", i), 32'(bc_data), 32'(VEC[i].wd));
            check($sformatf("R7 head valid v%0d", i), 32'(head_valid), 32'(VEC[i].ehv));
            if (VEC[i].ehv) check($sformatf("R7 head tag v%0d", i), 32'(head_tag), 32'(VEC[i].eht));
            step();
        end
        idle();
        #1;

        // After the walk: order 3,0,1,2 live, none written, entry 4 free.
        lk_tag[0] = 3'd2;
        lk_tag[1] = 3'd3;
        #1;
        check("R4 write to free entry left no ready", 32'(lk_ready[0]), 32'd0);
        check("R5 unwritten entry not ready", 32'(lk_ready[1]), 32'd0);
        lk_tag[1] = 3'd4;
        #1;
        check("R5 free entry not ready", 32'(lk_ready[1]), 32'd0);

        // R6: forwarding of a same-cycle write
        wr_en     = 1'b1;
        wr_tag    = 3'd3;
        wr_data   = 16'h0055;
        lk_tag[0] = 3'd3;
        #1;
        check("R6 forward ready", 32'(lk_ready[0]), 32'd1);
        check("R6 forward data", 32'(lk_data[0]), 32'h55);
        check("R4 bc tag", 32'(bc_tag), 32'd3);
        step();
        wr_en = 1'b0;
        #1;
        check("R5 stored ready", 32'(lk_ready[0]), 32'd1);
        check("R5 stored data", 32'(lk_data[0]), 32'h55);

        // R7: head contents and retirement
        check("R7 head tag", 32'(head_tag), 32'd3);
        check("R7 head ready", 32'(head_ready), 32'd1);
        check("R7 head areg", 32'(head_areg), 32'd4);
        check("R7 head data", 32'(head_data), 32'h55);
        retire = 1'b1;
        step();
        #1;
        check("R7 next head tag", 32'(head_tag), 32'd0);
        check("R7 next head areg", 32'(head_areg), 32'd7);
        check("R7 next head not ready", 32'(head_ready), 32'd0);
        step();
        retire = 1'b0;
        #1;
        check("R7 unready retire ignored", 32'(head_tag), 32'd0);
        check("R7 unready retire keeps valid", 32'(head_valid), 32'd1);

        // R1: reset clears everything again
        do_reset();
        check("R1 head cleared", 32'(head_valid), 32'd0);
        lk_tag[0] = 3'd3;
        #1;
        check("R1 lookup cleared", 32'(lk_ready[0]), 32'd0);
        disp_req = 2'b11;
        #1;
        check("R1 both slots granted", 32'(disp_gnt), 32'd3);
        check("R1 first tag", 32'(disp_tag[0]), 32'd0);
        check("R1 second tag", 32'(disp_tag[1]), 32'd1);
        disp_req = 2'b10;
        #1;
        check("R3 slot1 alone not granted", 32'(disp_gnt), 32'd0);

        // R8: flush across the sequence wrap (14,15 kept; 0,1 discarded by branch 15)
        disp_req    = 2'b11;
        disp_seq[0] = 4'd14;
        disp_seq[1] = 4'd15;
        step();
        disp_seq[0] = 4'd0;
        disp_seq[1] = 4'd1;
        #1;
        check("R2 wrap alloc tags", 32'(disp_tag[0]), 32'd2);
        step();
        idle();
        flush     = 1'b1;
        flush_seq = 4'd15;
        retire    = 1'b1;
        step();
        idle();
        disp_req = 2'b11;
        #1;
        check("R8 freed first tag", 32'(disp_tag[0]), 32'd2);
        check("R8 freed second tag", 32'(disp_tag[1]), 32'd3);
        check("R8 grants after flush", 32'(disp_gnt), 32'd3);
        check("R8 older head kept", 32'(head_tag), 32'd0);
        check("R8 head survives", 32'(head_valid), 32'd1);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule